// File: doc/BRIEF.md
# Extended-Precision Truncating Remainder Unit

This unit computes the remainder of two extended-precision floating-point numbers when the quotient is truncated toward zero. Each operand is a packed word made of a sign bit, a biased exponent field and a significand with an explicit integer bit. The default format is 80 bits: a 15-bit exponent and a 64-bit significand. Both widths are parameters, so a narrow format can stand in for the wide one during verification.

The unit first takes the special operands out of the normal path. These are NaNs, infinities, zeros, and a dividend whose magnitude exponent lies below the divisor's. Subnormal operands are normalized. The significand remainder is then found with a restoring division that makes one compare, subtract and shift decision per clock cycle, for as many steps as the exponent difference plus one. The remainder carries the divisor's exponent. A single leading-zero shift moves it back to normal form, or to subnormal form when the exponent is too small. The result is exact and needs no rounding.

A caller pulses `start` with both operands present while `busy` is low. It then waits for the one-cycle `done` pulse, which comes with `result` and `invalid`.

Top module: `fprem_unit`

## Requirements
- R1: If either operand is a NaN, the result is a NaN copied from the dividend if the dividend is a NaN, and otherwise from the divisor. In both cases the quiet bit (significand bit SIG_W-2) is set. A NaN has an all-ones exponent field and a nonzero significand below the integer bit.
- R2: `invalid` is raised when either operand is a signaling NaN (a NaN with significand bit SIG_W-2 clear). A quiet NaN alone does not raise it.
- R3: An infinite dividend (all-ones exponent, zero significand below the integer bit) with a non-NaN divisor gives the default NaN and raises `invalid`. The default NaN has sign 0, an all-ones exponent and an all-ones significand.
- R4: A zero divisor (exponent and significand both zero) with a finite, non-NaN dividend gives the default NaN and raises `invalid`.
- R5: An infinite divisor with a finite dividend returns the dividend word unchanged, with `invalid` low.
- R6: A zero dividend with a finite nonzero divisor is returned unchanged, keeping its sign, with `invalid` low.
- R7: When the dividend's effective exponent is below the divisor's, the dividend word is returned unchanged. For a subnormal operand, the effective exponent is 1 minus the leading-zero count of its significand.
- R8: For finite nonzero operands, the result magnitude is |a| - n*|b| with n = trunc(|a|/|b|), and the result takes the sign of the dividend. It is encoded exactly: with the integer bit set when the exponent field is nonzero, or as a subnormal (exponent field 0) when it is too small.
- R9: A remainder of exactly zero is returned as a zero that carries the dividend's sign.
- R10: Subnormal dividends and divisors are normalized before division, so R8 holds for them too. A divisor with a nonzero exponent field is treated as having its integer bit set.
- R11: `start` is accepted only while `busy` is low. A `start` raised while busy has no effect on the result in flight and produces no extra `done`.
- R12: After reset, `busy`, `done`, `result` and `invalid` are low. Counting the rising edge that accepts `start` as edge 1, `done` appears after edge 3 for the special cases in R1 to R7, and after edge d+4 for a division with effective exponent difference d. `done` lasts one cycle, and `busy` is high from edge 1 until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only when not busy |
| op_a | input | 1+EXP_W+SIG_W | Dividend: sign, exponent field, significand |
| op_b | input | 1+EXP_W+SIG_W | Divisor: sign, exponent field, significand |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when result and invalid are valid |
| result | output | 1+EXP_W+SIG_W | Remainder, held until the next done |
| invalid | output | 1 | Invalid-operation flag for the finished operation |

## Verification
The hardest results to reach are the ones that come out subnormal. They only occur when the divisor itself is near the bottom of the exponent range, or is subnormal, and the significand loop leaves a remainder with many leading zeros. Random wide-format operands almost never land there. The bench therefore runs a 5-bit exponent and 8-bit significand format and sweeps every pair of exponent fields. For each field value it derives significands that include zero, subnormal, infinite and both NaN kinds. The expected values come from exact integer arithmetic on the scaled magnitudes, and the latency is checked on every vector.

// File: rtl/fprem_pkg.sv
package fprem_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PREP = 2'd1,
    S_LOOP = 2'd2,
    S_FIN  = 2'd3
  } fprem_state_e;

endpackage

// File: rtl/fprem_classify.sv
module fprem_classify #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W-1:0] exp_f,
  input  logic [SIG_W-1:0] sig,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_inf,
  output logic             is_zero
);
  localparam int QBIT = SIG_W - 2;

  logic exp_top;
  logic frac_nz;

  always_comb begin
    exp_top = &exp_f;
    frac_nz = |sig[SIG_W-2:0];
    is_nan  = exp_top && frac_nz;
    is_snan = is_nan && !sig[QBIT];
    is_inf  = exp_top && !frac_nz;
    is_zero = (exp_f == '0) && (sig == '0);
  end
endmodule

// File: rtl/fprem_lzc.sv
module fprem_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  logic found;

  always_comb begin
    cnt   = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fprem_divstep.sv
module fprem_divstep #(
  parameter int SIG_W = 64
) (
  input  logic [SIG_W-1:0] rem_in,
  input  logic [SIG_W-1:0] div,
  input  logic             shift,
  output logic [SIG_W-1:0] rem_out
);
  logic [SIG_W:0] trial;
  logic [SIG_W:0] diff;

  always_comb begin
    trial = shift ? {rem_in, 1'b0} : {1'b0, rem_in};
    diff  = trial - {1'b0, div};
    rem_out = (trial >= {1'b0, div}) ? diff[SIG_W-1:0] : trial[SIG_W-1:0];
  end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [EXP_W+SIG_W:0]     op_a,
  input  logic [EXP_W+SIG_W:0]     op_b,
  output logic                     busy,
  output logic                     done,
  output logic [EXP_W+SIG_W:0]     result,
  output logic                     invalid
);
  import fprem_pkg::*;

  localparam int FMT_W = 1 + EXP_W + SIG_W;
  localparam int XW    = EXP_W + 2;
  localparam int LZW   = $clog2(SIG_W + 1);
  localparam int QBIT  = SIG_W - 2;
  localparam logic [FMT_W-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, {SIG_W{1'b1}}};
  localparam logic [FMT_W-1:0] QMASK = {{(FMT_W-QBIT-1){1'b0}}, 1'b1, {QBIT{1'b0}}};
  localparam logic [SIG_W-1:0] IBIT  = {1'b1, {(SIG_W-1){1'b0}}};
  localparam logic signed [XW-1:0] ONE_X = 1;

  fprem_state_e st;

  logic [FMT_W-1:0] a_q, b_q;
  logic [SIG_W-1:0] rem_q, div_q;
  logic signed [XW-1:0] eb_q;
  logic [XW-1:0]    cnt_q;
  logic             first_q;
  logic             spec_q, spec_inv_q;
  logic [FMT_W-1:0] spec_res_q;

  // operand fields
  logic             a_sign;
  logic [EXP_W-1:0] a_exp, b_exp;
  logic [SIG_W-1:0] a_sig, b_sig, b_fix;

  assign a_sign = a_q[FMT_W-1];
  assign a_exp  = a_q[FMT_W-2 -: EXP_W];
  assign b_exp  = b_q[FMT_W-2 -: EXP_W];
  assign a_sig  = a_q[SIG_W-1:0];
  assign b_sig  = b_q[SIG_W-1:0];
  assign b_fix  = (b_exp != '0) ? (b_sig | IBIT) : b_sig;

  logic a_nan, a_snan, a_inf, a_zero;
  logic b_nan, b_snan, b_inf, b_zero;

  fprem_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_a (
    .exp_f(a_exp), .sig(a_sig),
    .is_nan(a_nan), .is_snan(a_snan), .is_inf(a_inf), .is_zero(a_zero)
  );

  fprem_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls_b (
    .exp_f(b_exp), .sig(b_sig),
    .is_nan(b_nan), .is_snan(b_snan), .is_inf(b_inf), .is_zero(b_zero)
  );

  logic [LZW-1:0] lz_a, lz_b, lz_r;

  fprem_lzc #(.W(SIG_W), .CW(LZW)) u_lz_a (.v(a_sig), .cnt(lz_a));
  fprem_lzc #(.W(SIG_W), .CW(LZW)) u_lz_b (.v(b_fix), .cnt(lz_b));
  fprem_lzc #(.W(SIG_W), .CW(LZW)) u_lz_r (.v(rem_q), .cnt(lz_r));

  // normalized operands and effective exponents
  logic signed [XW-1:0] a_base, b_base, lza_x, lzb_x, lzr_x;
  logic signed [XW-1:0] ea_eff, eb_eff;
  logic [SIG_W-1:0]     a_norm, b_norm;

  always_comb begin
    a_base = (a_exp == '0) ? ONE_X : {2'b00, a_exp};
    b_base = (b_exp == '0) ? ONE_X : {2'b00, b_exp};
    lza_x  = {{(XW-LZW){1'b0}}, lz_a};
    lzb_x  = {{(XW-LZW){1'b0}}, lz_b};
    lzr_x  = {{(XW-LZW){1'b0}}, lz_r};
    ea_eff = a_base - lza_x;
    eb_eff = b_base - lzb_x;
    a_norm = a_sig << lz_a;
    b_norm = b_fix << lz_b;
  end

  // special-operand screen, priority ordered
  logic             pick_spec, pick_inv;
  logic [FMT_W-1:0] pick_res;

  always_comb begin
    pick_spec = 1'b1;
    pick_inv  = 1'b0;
    pick_res  = a_q;
    if (a_nan) begin
      pick_res = a_q | QMASK;
      pick_inv = a_snan | b_snan;
    end else if (b_nan) begin
      pick_res = b_q | QMASK;
      pick_inv = b_snan;
    end else if (a_inf) begin
      pick_res = DNAN;
      pick_inv = 1'b1;
    end else if (b_inf) begin
      pick_res = a_q;
    end else if (b_zero) begin
      pick_res = DNAN;
      pick_inv = 1'b1;
    end else if (a_zero) begin
      pick_res = a_q;
    end else if (ea_eff < eb_eff) begin
      pick_res = a_q;
    end else begin
      pick_spec = 1'b0;
    end
  end

  // one restoring step
  logic [SIG_W-1:0] step_rem;

  fprem_divstep #(.SIG_W(SIG_W)) u_step (
    .rem_in(rem_q), .div(div_q), .shift(!first_q), .rem_out(step_rem)
  );

  // final renormalization of the remainder
  logic signed [XW-1:0] tgt;
  logic [XW-1:0]        sh_up, sh_dn;
  logic [FMT_W-1:0]     fin_res;

  always_comb begin
    tgt   = eb_q - lzr_x;
    sh_up = eb_q - ONE_X;
    sh_dn = ONE_X - eb_q;
    if (rem_q == '0)
      fin_res = {a_sign, {EXP_W{1'b0}}, {SIG_W{1'b0}}};
    else if (tgt >= ONE_X)
      fin_res = {a_sign, tgt[EXP_W-1:0], rem_q << lz_r};
    else if (eb_q >= ONE_X)
      fin_res = {a_sign, {EXP_W{1'b0}}, rem_q << sh_up};
    else
      fin_res = {a_sign, {EXP_W{1'b0}}, rem_q >> sh_dn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      a_q        <= '0;
      b_q        <= '0;
      rem_q      <= '0;
      div_q      <= '0;
      eb_q       <= '0;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      spec_q     <= 1'b0;
      spec_inv_q <= 1'b0;
      spec_res_q <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      invalid    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            a_q  <= op_a;
            b_q  <= op_b;
            busy <= 1'b1;
            st   <= S_PREP;
          end
        end
        S_PREP: begin
          spec_q     <= pick_spec;
          spec_inv_q <= pick_inv;
          spec_res_q <= pick_res;
          rem_q      <= a_norm;
          div_q      <= b_norm;
          eb_q       <= eb_eff;
          cnt_q      <= ea_eff - eb_eff;
          first_q    <= 1'b1;
          st         <= pick_spec ? S_FIN : S_LOOP;
        end
        S_LOOP: begin
          rem_q   <= step_rem;
          first_q <= 1'b0;
          if (cnt_q == '0) st <= S_FIN;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          result  <= spec_q ? spec_res_q : fin_res;
          invalid <= spec_q & spec_inv_q;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R11
  hold_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP) |-> ($stable(a_q) && $stable(b_q)));

  // R8
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP && !first_q) |-> (rem_q < div_q));

  // R10
  div_norm_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP) |-> div_q[SIG_W-1]);

  // R12
  loop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOP && cnt_q != '0) |=> (st == S_LOOP && cnt_q == $past(cnt_q) - 1'b1));

  // R3
  inv_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (done && invalid) |-> ((&result[FMT_W-2 -: EXP_W]) && result[QBIT]));
endmodule

// File: tb/fprem_unit_tb.sv
module fprem_unit_tb;
  localparam int EW = 5;
  localparam int SW = 8;
  localparam int FW = 1 + EW + SW;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] op_a = '0;
  logic [FW-1:0] op_b = '0;
  logic          busy, done, invalid;
  logic [FW-1:0] result;

  int nvec  = 0;
  int nfail = 0;

  fprem_unit #(.EXP_W(EW), .SIG_W(SW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result), .invalid(invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int msb_of(longint v);
    int p = -1;
    for (int i = 0; i < 63; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic [FW-1:0] encode(logic sgn, longint r);
    int p;
    int e;
    longint s;
    if (r == 0) return {sgn, {EW{1'b0}}, {SW{1'b0}}};
    p = msb_of(r);
    e = p - SW + 2;
    if (e >= 1) begin
      s = r >> (e - 1);
      return {sgn, EW'(e), SW'(s)};
    end
    return {sgn, {EW{1'b0}}, SW'(r)};
  endfunction

  // reference model: result, invalid, latency in edges, requirement tag
  task automatic ref_calc(input logic [FW-1:0] a, input logic [FW-1:0] b,
                          output logic [FW-1:0] er, output logic ei,
                          output int lat, output string tag);
    logic sa = a[FW-1];
    int ea = int'(a[FW-2 -: EW]);
    int eb = int'(b[FW-2 -: EW]);
    logic [SW-1:0] sga = a[SW-1:0];
    logic [SW-1:0] sgb = b[SW-1:0];
    int emax = (1 << EW) - 1;
    logic an  = (ea == emax) && (sga[SW-2:0] != 0);
    logic bn  = (eb == emax) && (sgb[SW-2:0] != 0);
    logic asn = an && !sga[SW-2];
    logic bsn = bn && !sgb[SW-2];
    logic ai  = (ea == emax) && (sga[SW-2:0] == 0);
    logic bi  = (eb == emax) && (sgb[SW-2:0] == 0);
    logic az  = (ea == 0) && (sga == 0);
    logic bz  = (eb == 0) && (sgb == 0);
    logic [FW-1:0] dnan = {1'b0, {EW{1'b1}}, {SW{1'b1}}};
    logic [FW-1:0] qm = FW'(1) << (SW - 2);
    int effa, effb;
    longint ma, mb, r;
    lat = 3;
    ei  = 1'b0;
    er  = a;
    effa = (ea != 0) ? ea : 1 - (SW - 1 - msb_of(longint'(sga)));
    effb = (eb != 0) ? eb : 1 - (SW - 1 - msb_of(longint'(sgb)));
    if (an) begin er = a | qm; ei = asn | bsn; tag = "R1 R2"; end
    else if (bn) begin er = b | qm; ei = bsn; tag = "R1 R2"; end
    else if (ai) begin er = dnan; ei = 1'b1; tag = "R3"; end
    else if (bi) begin er = a; tag = "R5"; end
    else if (bz) begin er = dnan; ei = 1'b1; tag = "R4"; end
    else if (az) begin er = a; tag = "R6"; end
    else if (effa < effb) begin er = a; tag = "R7"; end
    else begin
      ma = longint'(sga) << ((ea == 0 ? 1 : ea) - 1);
      mb = longint'(sgb) << ((eb == 0 ? 1 : eb) - 1);
      r  = ma % mb;
      er = encode(sa, r);
      lat = effa - effb + 4;
      if (r == 0) tag = "R9";
      else if (ea == 0 || eb == 0) tag = "R10";
      else tag = "R8";
    end
  endtask

  task automatic run_vec(input logic [FW-1:0] a, input logic [FW-1:0] b);
    logic [FW-1:0] er;
    logic ei;
    int lat;
    string tag;
    int n;
    logic bsy, after;
    logic [FW-1:0] got;
    logic ginv;
    ref_calc(a, b, er, ei, lat, tag);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0; bsy = busy;
    while (!done && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    got = result; ginv = invalid;
    @(posedge clk);
    @(negedge clk); after = done;
    nvec++;
    if (got !== er || ginv !== ei || n != lat || bsy !== 1'b1 || after !== 1'b0) begin
      nfail++;
      $display("FAIL %s R12 a=%h b=%h got=%h inv=%0b edges=%0d busy=%0b done_after=%0b exp=%h inv=%0b edges=%0d busy=1 done_after=0",
               tag, a, b, got, ginv, n, bsy, after, er, ei, lat);
    end
  endtask

  function automatic logic [SW-1:0] pick_sig(int e, int other, int k);
    int h = (e * 53 + other * 29 + k * 97 + 17) & 255;
    if (e == 0) return ((other + k) % 4 == 0) ? SW'(0) : SW'(h & 8'h7F);
    if (e == 31) begin
      case ((other + k) % 3)
        0: return 8'h80;
        1: return SW'(8'hC0 | (h & 8'h3F));
        default: return SW'(8'h81 | (h & 8'h3F));
      endcase
    end
    return SW'(8'h80 | h);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL R12 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [FW-1:0] er, a1, b1;
    logic ei;
    int lat, dcount;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    nvec++;
    if (busy !== 1'b0 || done !== 1'b0 || result !== '0 || invalid !== 1'b0) begin
      nfail++;
      $display("FAIL R12 reset busy=%0b done=%0b result=%h inv=%0b exp=0/0/0/0",
               busy, done, result, invalid);
    end

    // directed: zero remainder with negative dividend (R9), subnormal result (R8 R10)
    run_vec({1'b1, 5'd17, 8'hC0}, {1'b0, 5'd16, 8'hC0});
    run_vec({1'b0, 5'd3, 8'hF1}, {1'b1, 5'd0, 8'h0B});
    run_vec({1'b0, 5'd1, 8'hFF}, {1'b0, 5'd1, 8'h81});
    run_vec({1'b1, 5'd30, 8'hFF}, {1'b0, 5'd0, 8'h01});

    // R11: start while busy is ignored
    a1 = {1'b0, 5'd30, 8'hB3};
    b1 = {1'b0, 5'd1, 8'h81};
    ref_calc(a1, b1, er, ei, lat, tag);
    @(negedge clk); op_a = a1; op_b = b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); op_a = {1'b1, 5'd2, 8'h90}; op_b = {1'b0, 5'd2, 8'h88}; start = 1'b1;
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    dcount = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (done) begin
        dcount++;
        nvec++;
        if (result !== er || invalid !== ei) begin
          nfail++;
          $display("FAIL R11 result=%h inv=%0b exp=%h inv=%0b", result, invalid, er, ei);
        end
      end
    end
    nvec++;
    if (dcount != 1) begin
      nfail++;
      $display("FAIL R11 done pulses=%0d exp=1", dcount);
    end

    // sweep over every pair of exponent fields
    for (int ea = 0; ea < 32; ea++) begin
      for (int eb = 0; eb < 32; eb++) begin
        for (int k = 0; k < 2; k++) begin
          logic sa = logic'((ea + k) & 1);
          logic sb = logic'(((eb >> 1) ^ k) & 1);
          run_vec({sa, EW'(ea), pick_sig(ea, eb, k)},
                  {sb, EW'(eb), pick_sig(eb, ea, k)});
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule